// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a chain of boundary scan cells that sits between a device's core logic and its pins. It is driven by a test access port controller. That controller supplies serial data and the capture, shift and update strobes, plus a mode code. The chain returns one serial output bit toward the scan output pin. Every cell has a capture/shift stage and an update latch. Input pins get one cell each. Each output pin gets two cells: one for its data and one for its enable.

In functional mode the core reaches the pins unchanged. Capture, shift and update still work in this mode, so live traffic can be sampled and test values can be preloaded into the update latches. In external test mode the update latches drive the pins and the pins are observed. In internal test mode the input latches drive the core instead of the pins.

Top module: `bscan_chain`

## Requirements
- R1: When the registered mode is functional, `pad_out_o`, `pad_oe_o` and `core_in_o` equal `core_out_i`, `core_oe_i` and `pad_in_i` respectively. Mode codes 0 and 3 both mean functional.
- R2: `mode_i` is registered on each clock edge and takes effect after that edge. The codes are: 0 functional, 1 external test, 2 internal test, 3 functional.
- R3: A capture strobe loads every cell stage in one edge, and capture wins over shift. Cell k < N_IN takes `pad_in_i[k]`, or its own update latch value in internal test mode. For output pin j, cell N_IN+2j takes `core_oe_i[j]` and cell N_IN+2j+1 takes `core_out_i[j]`.
- R4: A shift strobe without capture moves the chain one cell toward the output. `tdi_i` enters cell 0, and `tdo_o` shows the stage of the last cell (N_IN+2*N_OUT-1).
- R5: The update latches copy the cell stages only on an update strobe. Shifting and capturing leave the latches, and therefore the driven pins, unchanged.
- R6: Capture, shift and update in functional mode have no effect on `pad_out_o`, `pad_oe_o` or `core_in_o`, so the chain can sample live traffic and preload test values.
- R7: In external test mode, `pad_out_o[j]` comes from latch N_IN+2j+1, so preloaded values appear as soon as the mode takes effect. In this mode `core_in_o` still follows `pad_in_i`.
- R8: In either test mode, `pad_oe_o[j]` comes from control latch N_IN+2j. A value of 0 means the pin is released (high impedance) and 1 means it is driven.
- R9: In internal test mode, `core_in_o[k]` comes from latch k, and the pins stay driven from the latches as in R7 and R8.
- R10: Asynchronous active-low reset clears all stages and latches and forces the mode to functional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tdi_i | input | 1 | Serial data in |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| mode_i | input | 2 | Mode code |
| tdo_o | output | 1 | Serial data out |
| core_out_i | input | N_OUT | Core output data |
| core_oe_i | input | N_OUT | Core output enables |
| core_in_o | output | N_IN | Data presented to the core |
| pad_in_i | input | N_IN | Values on input pins |
| pad_out_o | output | N_OUT | Data toward output pins |
| pad_oe_o | output | N_OUT | Output pin drive enables |

## Verification
The hardest situation to reach is a pin driven from a latch that was loaded while the device was still functional. Reaching it takes a full-length preload shift, an update, a mode change, and then a check that the pins switch only at that change. The stimulus shifts a known pattern in under functional mode, with live core values on the pins. It confirms the pins still follow the core, selects external test, and then shifts a second pattern without updating. This shows that the latches, not the stages, drive the pins. A final internal test pass captures the latch values back through the input cells, so the loop from latch to capture is observed at the serial output.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    BS_FUNC   = 2'd0,
    BS_EXTEST = 2'd1,
    BS_INTEST = 2'd2,
    BS_RSVD   = 2'd3
  } bs_mode_e;
endpackage

// File: rtl/bsc_cell.sv
module bsc_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic cap_i,
  input  logic ser_i,
  output logic ser_o,
  output logic upd_o
);
  logic stage_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      if (capture_i)    stage_q <= cap_i;
      else if (shift_i) stage_q <= ser_i;
      if (update_i)     upd_q   <= stage_q;
    end
  end

  assign ser_o = stage_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/bsc_mode_ctl.sv
module bsc_mode_ctl
  import bscan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output logic       drive_pins_o,
  output logic       intest_o
);
  bs_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= BS_FUNC;
    else         mode_q <= bs_mode_e'(mode_i);
  end

  always_comb begin
    drive_pins_o = 1'b0;
    intest_o     = 1'b0;
    unique case (mode_q)
      BS_EXTEST: drive_pins_o = 1'b1;
      BS_INTEST: begin
        drive_pins_o = 1'b1;
        intest_o     = 1'b1;
      end
      default: ;  // reserved code behaves as functional
    endcase
  end
endmodule

// File: rtl/bsc_pin_mux.sv
module bsc_pin_mux #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             drive_pins_i,
  input  logic             intest_i,
  input  logic [N_OUT-1:0] core_out_i,
  input  logic [N_OUT-1:0] core_oe_i,
  input  logic [N_IN-1:0]  pad_in_i,
  input  logic [N_IN-1:0]  upd_in_i,
  input  logic [N_OUT-1:0] upd_out_i,
  input  logic [N_OUT-1:0] upd_oe_i,
  output logic [N_OUT-1:0] pad_out_o,
  output logic [N_OUT-1:0] pad_oe_o,
  output logic [N_IN-1:0]  core_in_o
);
  assign pad_out_o = drive_pins_i ? upd_out_i : core_out_i;
  assign pad_oe_o  = drive_pins_i ? upd_oe_i  : core_oe_i;
  assign core_in_o = intest_i     ? upd_in_i  : pad_in_i;
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tdi_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic [1:0]       mode_i,
  output logic             tdo_o,
  input  logic [N_OUT-1:0] core_out_i,
  input  logic [N_OUT-1:0] core_oe_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_IN-1:0]  pad_in_i,
  output logic [N_OUT-1:0] pad_out_o,
  output logic [N_OUT-1:0] pad_oe_o
);
  localparam int L = N_IN + 2 * N_OUT;

  logic [L:0]       ser;
  logic [L-1:0]     cap_d, sr_q, upd_q;
  logic [N_IN-1:0]  upd_in;
  logic [N_OUT-1:0] upd_out, upd_oe;
  logic             drive_pins, intest;

  assign ser[0] = tdi_i;
  assign tdo_o  = ser[L];
  assign sr_q   = ser[L:1];

  bsc_mode_ctl i_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .drive_pins_o(drive_pins),
    .intest_o    (intest)
  );

  for (genvar k = 0; k < N_IN; k++) begin : g_in
    assign cap_d[k]  = intest ? upd_q[k] : pad_in_i[k];
    assign upd_in[k] = upd_q[k];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    assign cap_d[N_IN+2*j]   = core_oe_i[j];
    assign cap_d[N_IN+2*j+1] = core_out_i[j];
    assign upd_oe[j]         = upd_q[N_IN+2*j];
    assign upd_out[j]        = upd_q[N_IN+2*j+1];
  end

  for (genvar c = 0; c < L; c++) begin : g_cell
    bsc_cell i_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .capture_i(capture_i),
      .shift_i  (shift_i),
      .update_i (update_i),
      .cap_i    (cap_d[c]),
      .ser_i    (ser[c]),
      .ser_o    (ser[c+1]),
      .upd_o    (upd_q[c])
    );
  end

  bsc_pin_mux #(.N_IN(N_IN), .N_OUT(N_OUT)) i_mux (
    .drive_pins_i(drive_pins),
    .intest_i    (intest),
    .core_out_i  (core_out_i),
    .core_oe_i   (core_oe_i),
    .pad_in_i    (pad_in_i),
    .upd_in_i    (upd_in),
    .upd_out_i   (upd_out),
    .upd_oe_i    (upd_oe),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .core_in_o   (core_in_o)
  );
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      tdi_i,
  input logic                      capture_i,
  input logic                      shift_i,
  input logic                      update_i,
  input logic [1:0]                mode_i,
  input logic [N_OUT-1:0]          core_out_i,
  input logic [N_OUT-1:0]          core_oe_i,
  input logic [N_OUT-1:0]          pad_out_o,
  input logic [N_OUT-1:0]          pad_oe_o,
  input logic [N_IN+2*N_OUT-1:0]   sr_q,
  input logic [N_IN+2*N_OUT-1:0]   upd_q
);
  localparam int L = N_IN + 2 * N_OUT;

  logic             past_ok_q;
  logic [N_OUT-1:0] lat_oe, lat_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_sel
    assign lat_oe[j]  = upd_q[N_IN+2*j];
    assign lat_out[j] = upd_q[N_IN+2*j+1];
  end

  // R1
  func_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && ($past(mode_i) == 2'd0 || $past(mode_i) == 2'd3))
      |-> (pad_out_o == core_out_i && pad_oe_o == core_oe_i));

  // R4
  shift_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> (sr_q == {$past(sr_q[L-2:0]), $past(tdi_i)}));

  // R5
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(upd_q));

  // R5
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (upd_q == $past(sr_q)));

  // R7
  extest_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(mode_i) == 2'd1) |-> (pad_out_o == lat_out));

  // R8
  oe_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && ($past(mode_i) == 2'd1 || $past(mode_i) == 2'd2))
      |-> (pad_oe_o == lat_oe));
endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) i_chk (.*);

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
  localparam int N_IN  = 4;
  localparam int N_OUT = 3;
  localparam int L     = N_IN + 2 * N_OUT;

  typedef struct {
    string            req;
    logic [N_OUT-1:0] po;
    logic [N_OUT-1:0] poe;
    logic [N_IN-1:0]  ci;
    logic             tdo;
  } exp_t;

  logic             clk = 1'b0, rst_ni = 1'b0;
  logic             tdi_i = 1'b0, capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0;
  logic [1:0]       mode_i = 2'd0;
  logic             tdo_o;
  logic [N_OUT-1:0] core_out_i = '0, core_oe_i = '0, pad_out_o, pad_oe_o;
  logic [N_IN-1:0]  pad_in_i = '0, core_in_o;

  exp_t q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;

  logic [L-1:0] m_sr = '0, m_upd = '0;
  logic [1:0]   m_mode = 2'd0;

  always #5 clk = ~clk;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) i_bscan_chain (
    .clk_i(clk), .rst_ni(rst_ni), .tdi_i(tdi_i), .capture_i(capture_i),
    .shift_i(shift_i), .update_i(update_i), .mode_i(mode_i), .tdo_o(tdo_o),
    .core_out_i(core_out_i), .core_oe_i(core_oe_i), .core_in_o(core_in_o),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  function automatic exp_t predict(string req);
    exp_t e;
    logic drive;
    drive = (m_mode == 2'd1 || m_mode == 2'd2);
    e.req = req;
    for (int j = 0; j < N_OUT; j++) begin
      e.po[j]  = drive ? m_upd[N_IN+2*j+1] : core_out_i[j];
      e.poe[j] = drive ? m_upd[N_IN+2*j]   : core_oe_i[j];
    end
    e.ci  = (m_mode == 2'd2) ? m_upd[N_IN-1:0] : pad_in_i;
    e.tdo = m_sr[L-1];
    return e;
  endfunction

  // one clock with given strobes, mode and serial bit; pushes expectation
  task automatic step(input bit cap, input bit sh, input bit up,
                      input logic [1:0] md, input bit din, input string req);
    logic [L-1:0] cv, old_sr;
    @(negedge clk); #2;
    capture_i = cap; shift_i = sh; update_i = up; mode_i = md; tdi_i = din;
    for (int k = 0; k < N_IN; k++) cv[k] = (m_mode == 2'd2) ? m_upd[k] : pad_in_i[k];
    for (int j = 0; j < N_OUT; j++) begin
      cv[N_IN+2*j]   = core_oe_i[j];
      cv[N_IN+2*j+1] = core_out_i[j];
    end
    @(posedge clk); #1;
    old_sr = m_sr;
    if (cap)     m_sr = cv;
    else if (sh) m_sr = {m_sr[L-2:0], din};
    if (up)      m_upd = old_sr;
    m_mode = (md == 2'd1 || md == 2'd2) ? md : 2'd0;
    q.push_back(predict(req));
  endtask

  task automatic set_io(input logic [N_OUT-1:0] co, input logic [N_OUT-1:0] coe,
                        input logic [N_IN-1:0] pin);
    @(negedge clk); #2;
    core_out_i = co; core_oe_i = coe; pad_in_i = pin;
    capture_i = 1'b0; shift_i = 1'b0; update_i = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic shift_word(input logic [L-1:0] w, input logic [1:0] md, input string req);
    for (int b = L - 1; b >= 0; b--) step(1'b0, 1'b1, 1'b0, md, w[b], req);
  endtask

  task automatic async_reset(input string req);
    @(negedge clk); #2;
    rst_ni = 1'b0;
    capture_i = 1'b0; shift_i = 1'b0; update_i = 1'b0;
    m_sr = '0; m_upd = '0; m_mode = 2'd0;
    @(posedge clk); #1;
    q.push_back(predict(req));
    @(negedge clk); #2;
    rst_ni = 1'b1;
    mode_i = 2'd0;
  endtask

  // monitor: compare at falling edges
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (pad_out_o !== e.po || pad_oe_o !== e.poe || core_in_o !== e.ci || tdo_o !== e.tdo) begin
          n_bad++;
          $display("FAIL %s: got po=%b oe=%b ci=%b tdo=%b exp po=%b oe=%b ci=%b tdo=%b",
                   e.req, pad_out_o, pad_oe_o, core_in_o, tdo_o, e.po, e.poe, e.ci, e.tdo);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    q.push_back(predict("R10 reset state"));
    @(negedge clk); #2; rst_ni = 1'b1;

    // R1 functional passthrough, several patterns
    set_io(3'b101, 3'b110, 4'b1001);
    step(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R1 pass a");
    set_io(3'b010, 3'b011, 4'b0110);
    step(1'b0, 1'b0, 1'b0, 2'd3, 1'b0, "R1 pass code3");

    // R3 capture in functional mode, then R4 shift out
    set_io(3'b110, 3'b011, 4'b1010);
    step(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, "R3 capture wins");
    for (int b = 0; b < L - 1; b++) step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R4 shift out");

    // R6 preload while functional, update; pins still follow core
    shift_word(10'b1011_0110_01, 2'd0, "R6 preload shift");
    step(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, "R6 preload update");
    set_io(3'b001, 3'b100, 4'b0011);
    step(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R6 functional after preload");

    // R2 mode change takes effect after the edge, R7/R8 latches drive
    step(1'b0, 1'b0, 1'b0, 2'd1, 1'b0, "R2 R7 R8 extest select");
    set_io(3'b111, 3'b111, 4'b1100);
    step(1'b0, 1'b0, 1'b0, 2'd1, 1'b0, "R7 core ignored");

    // R5 shift in extest without update: pins hold
    shift_word(10'b0100_1001_10, 2'd1, "R5 hold during shift");
    step(1'b0, 1'b0, 1'b1, 2'd1, 1'b0, "R5 update applies");

    // R3 extest capture of pins then shift
    set_io(3'b000, 3'b010, 4'b0101);
    step(1'b1, 1'b0, 1'b0, 2'd1, 1'b0, "R3 extest capture");
    for (int b = 0; b < L - 1; b++) step(1'b0, 1'b1, 1'b0, 2'd1, 1'b0, "R4 extest shift");

    // R9 internal test: core sees latches, capture loops back
    shift_word(10'b0011_1100_11, 2'd1, "R9 load");
    step(1'b0, 1'b0, 1'b1, 2'd2, 1'b0, "R9 intest select");
    step(1'b0, 1'b0, 1'b0, 2'd2, 1'b0, "R9 core from latch");
    step(1'b1, 1'b0, 1'b0, 2'd2, 1'b0, "R9 R3 intest capture");
    for (int b = 0; b < L - 1; b++) step(1'b0, 1'b1, 1'b0, 2'd2, 1'b0, "R9 R4 intest shift");

    // R10 asynchronous reset while in test mode
    step(1'b0, 1'b0, 1'b0, 2'd1, 1'b0, "R8 before reset");
    async_reset("R10 async reset");
    step(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R10 functional after reset");

    @(negedge clk); #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule